// File: doc/BRIEF.md
# Shift-Based LMS Weight Increment Unit

This block performs the coefficient update step of a four-tap least-mean-square adaptive filter without a multiplier. The product of step size, error and input sample is replaced by an arithmetic right shift. The error is reduced to a signed power of two, taken from the position of the highest set bit of its magnitude. The step size is 2^(-PRE_SHIFT)/TAPS. Its two factors are applied as a fixed shift of every input sample.

Each update cycle, the caller presents the error word and the delayed input samples, one per tap, and asserts the update enable. A leading-one detector turns the error magnitude into a shift count. Each tap shifts its own sample through a logarithmic barrel shifter. A saturating add/subtract cell then moves the tap's weight up or down, depending on the error sign.

The shifted increments and the error sign are registered before the adder. The adder result is registered in the weight register, so the critical path holds one adder. The weight register is held inside the block. Its contents are driven out continuously, for the inner-product stage and for the next update.

Top module: `lms_shift_wupdate`

## Requirements
- R1: While reset is asserted, and after it is released, all weights read zero until the first accepted update.
- R2: For a nonzero error whose magnitude has its highest set bit at position p, every error bit below p is ignored. The increment for tap k is x_k >>> ((ERR_W-1-p) + PRE_SHIFT + log2(TAPS)).
- R3: When bit ERR_W-1 of the error (its sign) is 0, the increment is added to the weight.
- R4: When the error sign bit is 1, the increment is subtracted from the weight.
- R5: An error equal to zero leaves every weight unchanged, even with the update enable high.
- R6: With the update enable low, every weight is unchanged, whatever the error and samples are.
- R7: The shift is arithmetic. A negative sample keeps its sign and rounds toward minus infinity, so -1 stays -1 at any shift count.
- R8: A result above 2^(W-1)-1 is held at 2^(W-1)-1, and a result below -2^(W-1) is held at -2^(W-1). A weight never wraps.
- R9: Inputs sampled at one clock edge change the weight outputs at the following edge. Updates on consecutive cycles each take effect once, in order.
- R10: The most negative error, -2^(ERR_W-1), counts as magnitude 2^(ERR_W-1), giving a shift of PRE_SHIFT + log2(TAPS) and subtraction.
- R11: Each tap is updated only from its own sample and weight. Tap k occupies bits [k*W +: W] of the sample and weight buses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_en | input | 1 | Accept this cycle's error and samples as an update |
| err | input | ERR_W | Signed error word |
| x_taps | input | TAPS*W | Delayed input samples, tap k at [k*W +: W], signed |
| w_taps | output | TAPS*W | Current weights, tap k at [k*W +: W], signed |

## Verification
A wrong shift count from the leading-one detector scales every tap's weight by a power of two. This shows at the outputs one edge after the update is registered. An inverted sign select moves all weights the wrong way at that same edge. A missing saturation shows as a sudden jump of about 2^W on the tap that overflows. A fault in the enable or zero-error gating shows as a weight moving when no update was requested. The bench checks each update against an independent model two edges after driving it, so every such fault shows within one update.

// File: rtl/lms_inc_pkg.sv
package lms_inc_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  // Fixed right shift applied to every sample: step-size exponent plus log2 of tap count
  function automatic int fixed_shift(input int pre_shift, input int log2_taps);
    return pre_shift + log2_taps;
  endfunction

endpackage

// File: rtl/lms_lead_one.sv
module lms_lead_one #(
  parameter int ERR_W = 16,
  localparam int CNT_W = $clog2(ERR_W)
) (
  input  logic [ERR_W-1:0] mag,
  output logic [CNT_W-1:0] shamt,
  output logic             nonzero
);

  // Scan upward; the highest set bit is the last one to write shamt
  always_comb begin
    shamt   = '0;
    nonzero = |mag;
    for (int b = 0; b < ERR_W; b++) begin
      if (mag[b]) shamt = CNT_W'(ERR_W - 1 - b);
    end
  end

endmodule

// File: rtl/lms_barrel.sv
module lms_barrel #(
  parameter int W    = 16,
  parameter int SH_W = 4
) (
  input  logic signed [W-1:0]    din,
  input  logic        [SH_W-1:0] amt,
  output logic signed [W-1:0]    dout
);

  logic signed [W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  generate
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      if (STEP >= W) begin : g_fill
        assign stage[k+1] = amt[k] ? {W{stage[k][W-1]}} : stage[k];
      end else begin : g_shift
        assign stage[k+1] = amt[k] ? (stage[k] >>> STEP) : stage[k];
      end
    end
  endgenerate

  assign dout = stage[SH_W];

endmodule

// File: rtl/lms_sat_addsub.sv
module lms_sat_addsub
  import lms_inc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] w_cur,
  input  logic signed [W-1:0] inc,
  input  op_e                 op,
  output logic signed [W-1:0] w_nxt
);

  localparam logic signed [W-1:0] W_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] W_MIN = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] wide_w;
  logic signed [W:0] wide_i;
  logic signed [W:0] raw;

  always_comb begin
    wide_w = {w_cur[W-1], w_cur};
    wide_i = {inc[W-1], inc};
    raw    = (op == OP_SUB) ? (wide_w - wide_i) : (wide_w + wide_i);
    if (raw[W] != raw[W-1]) begin
      w_nxt = raw[W] ? W_MIN : W_MAX;
    end else begin
      w_nxt = raw[W-1:0];
    end
  end

endmodule

// File: rtl/lms_shift_wupdate.sv
module lms_shift_wupdate
  import lms_inc_pkg::*;
#(
  parameter int W         = 16,
  parameter int ERR_W     = 16,
  parameter int TAPS      = 4,
  parameter int PRE_SHIFT = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_en,
  input  logic signed [ERR_W-1:0] err,
  input  logic [TAPS*W-1:0]       x_taps,
  output logic [TAPS*W-1:0]       w_taps
);

  localparam int LOG2_TAPS = $clog2(TAPS);
  localparam int FIX_SH    = fixed_shift(PRE_SHIFT, LOG2_TAPS);
  localparam int CNT_W     = $clog2(ERR_W);

  // reset release synchronizer
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  // stage A: magnitude, leading one, per-tap shift
  logic [ERR_W-1:0] err_u;
  logic [ERR_W-1:0] mag_a;
  logic             neg_a;
  logic [CNT_W-1:0] t_a;
  logic             nz_a;

  assign err_u = err;
  assign neg_a = err_u[ERR_W-1];
  assign mag_a = neg_a ? (~err_u + 1'b1) : err_u;

  lms_lead_one #(.ERR_W(ERR_W)) u_lod (
    .mag     (mag_a),
    .shamt   (t_a),
    .nonzero (nz_a)
  );

  logic signed [W-1:0] inc_a [TAPS];
  logic signed [W-1:0] inc_q [TAPS];
  logic signed [W-1:0] inc_d [TAPS];
  logic signed [W-1:0] w_q   [TAPS];
  logic signed [W-1:0] w_nxt [TAPS];

  // pipeline register before the adder: next-state
  logic upd_d, upd_q;
  op_e  op_d, op_q;

  always_comb begin
    upd_d = upd_en & nz_a;
    op_d  = neg_a ? OP_SUB : OP_ADD;
    for (int k = 0; k < TAPS; k++) inc_d[k] = upd_d ? inc_a[k] : inc_q[k];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      upd_q <= 1'b0;
      op_q  <= OP_ADD;
      for (int k = 0; k < TAPS; k++) inc_q[k] <= '0;
    end else begin
      upd_q <= upd_d;
      if (upd_d) op_q <= op_d;
      for (int k = 0; k < TAPS; k++) inc_q[k] <= inc_d[k];
    end
  end

  // weight register after the adder, clock-enabled by the registered update flag
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int k = 0; k < TAPS; k++) w_q[k] <= '0;
    end else if (upd_q) begin
      for (int k = 0; k < TAPS; k++) w_q[k] <= w_nxt[k];
    end
  end

  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      logic signed [W-1:0] x_pre;
      assign x_pre = $signed(x_taps[k*W +: W]) >>> FIX_SH;

      lms_barrel #(.W(W), .SH_W(CNT_W)) u_shift (
        .din  (x_pre),
        .amt  (t_a),
        .dout (inc_a[k])
      );

      lms_sat_addsub #(.W(W)) u_acc (
        .w_cur (w_q[k]),
        .inc   (inc_q[k]),
        .op    (op_q),
        .w_nxt (w_nxt[k])
      );

      assign w_taps[k*W +: W] = w_q[k];

      // R3 R8
      up_move_chk: assert property (@(posedge clk) disable iff (!rst_i)
        (upd_q && ((op_q == OP_ADD && inc_q[k] >= 0) || (op_q == OP_SUB && inc_q[k] <= 0)))
          |=> (w_q[k] >= $past(w_q[k])));

      // R4 R8
      down_move_chk: assert property (@(posedge clk) disable iff (!rst_i)
        (upd_q && ((op_q == OP_SUB && inc_q[k] >= 0) || (op_q == OP_ADD && inc_q[k] <= 0)))
          |=> (w_q[k] <= $past(w_q[k])));
    end
  endgenerate

  // R2
  lod_pos_chk: assert property (@(posedge clk) disable iff (!rst_i)
    nz_a |-> ((mag_a >> (ERR_W - 1 - int'(t_a))) == ERR_W'(1)));

  // R5 R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (!upd_en || err == '0) |=> ##1 $stable(w_taps));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    (!rst_i) |-> (w_taps == '0));

endmodule

// File: tb/lms_shift_wupdate_test.sv
module lms_shift_wupdate_test;

  localparam int W     = 16;
  localparam int ERR_W = 16;
  localparam int TAPS  = 4;
  localparam int PRE   = 0;
  localparam int LOG2T = 2;
  localparam int NV    = 8;

  localparam int T_ERR [NV] = '{16384, 291, -12288, 1, -32768, 32767, -1, 2048};
  localparam int T_X [NV][TAPS] = '{
    '{4096, -4096, 32767, 1},
    '{32767, 16384, -32768, 256},
    '{8192, 8192, -8192, 100},
    '{32767, -32768, 12345, -1},
    '{16384, -16384, 4660, -1},
    '{-3, 5, -7, 9},
    '{1000, -1000, 20000, -20000},
    '{-32768, -32768, 32767, 32767}
  };

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    upd_en;
  logic signed [ERR_W-1:0] err;
  logic [TAPS*W-1:0]       x_taps;
  logic [TAPS*W-1:0]       w_taps;

  int checks = 0;
  int errors = 0;
  int model [TAPS];
  bit done = 0;

  always #5 clk = ~clk;

  lms_shift_wupdate #(.W(W), .ERR_W(ERR_W), .TAPS(TAPS), .PRE_SHIFT(PRE)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (upd_en),
    .err    (err),
    .x_taps (x_taps),
    .w_taps (w_taps)
  );

  function automatic longint model_inc(input int x, input int e);
    longint m;
    longint xs;
    int p;
    int sh;
    if (e == 0) return 0;
    m = (e < 0) ? -longint'(e) : longint'(e);
    p = 0;
    for (int b = 0; b < ERR_W; b++) if (((m >> b) & 1) == 1) p = b;
    sh = (ERR_W - 1 - p) + PRE + LOG2T;
    xs = longint'(x);
    return xs >>> sh;
  endfunction

  function automatic int model_next(input int w, input int x, input int e);
    longint r;
    r = (e < 0) ? (longint'(w) - model_inc(x, e)) : (longint'(w) + model_inc(x, e));
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic int tap_out(input int k);
    logic signed [W-1:0] v;
    v = w_taps[k*W +: W];
    return int'(v);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic drive(input logic en, input int e, input int xs [TAPS]);
    upd_en = en;
    err    = ERR_W'(e);
    for (int k = 0; k < TAPS; k++) x_taps[k*W +: W] = W'(xs[k]);
    if (en && e != 0) for (int k = 0; k < TAPS; k++) model[k] = model_next(model[k], xs[k], e);
  endtask

  // drive at a falling edge, idle the next, sample two rising edges later
  task automatic step(input logic en, input int e, input int xs [TAPS], input string tag);
    @(negedge clk);
    drive(en, e, xs);
    @(negedge clk);
    upd_en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < TAPS; k++) check(tag, tap_out(k), model[k]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < TAPS; k++) model[k] = 0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < TAPS; k++) check("R1 in reset", tap_out(k), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < TAPS; k++) check("R1 after release", tap_out(k), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got running expected finished");
      finish_run();
    end
  end

  initial begin
    int xs [TAPS];
    int base [TAPS];
    rst_n  = 1'b0;
    upd_en = 1'b0;
    err    = '0;
    x_taps = '0;
    for (int k = 0; k < TAPS; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < TAPS; k++) check("R1 reset state", tap_out(k), 0);

    // table walk: R2 R3 R4 R7 R10 R11
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < TAPS; k++) xs[k] = T_X[v][k];
      step(1'b1, T_ERR[v], xs, "R2/R3/R4/R7/R10/R11 table");
    end

    // R6: enable low, large error
    for (int k = 0; k < TAPS; k++) xs[k] = 30000;
    step(1'b0, 16384, xs, "R6 enable low");
    // R5: zero error with enable high
    step(1'b1, 0, xs, "R5 zero error");

    // R2: bits below the leading one ignored -> 0x4FFF equals 0x4000
    do_reset();
    for (int k = 0; k < TAPS; k++) xs[k] = 8192 * (k + 1) - 1;
    step(1'b1, 20479, xs, "R2 low bits ignored");
    for (int k = 0; k < TAPS; k++) check("R2 explicit", tap_out(k), (8192 * (k + 1) - 1) >>> 3);

    // R7: -1 stays -1 under the largest shift
    do_reset();
    for (int k = 0; k < TAPS; k++) xs[k] = -1;
    step(1'b1, 1, xs, "R7 floor shift");
    check("R7 explicit", tap_out(0), -1);

    // R9: back-to-back updates
    do_reset();
    for (int k = 0; k < TAPS; k++) xs[k] = 2048 << k;
    @(negedge clk);
    drive(1'b1, 16384, xs);
    for (int k = 0; k < TAPS; k++) base[k] = model[k];
    @(negedge clk);
    drive(1'b1, 16384, xs);
    @(negedge clk);
    upd_en = 1'b0;
    for (int k = 0; k < TAPS; k++) check("R9 first only", tap_out(k), base[k]);
    @(negedge clk);
    for (int k = 0; k < TAPS; k++) check("R9 both applied", tap_out(k), model[k]);

    // R8 R10: saturation both ways
    do_reset();
    xs = '{-32768, 32767, 0, 4};
    for (int n = 0; n < 5; n++) step(1'b1, -32768, xs, "R8 saturation path");
    check("R8 positive rail", tap_out(0), 32767);
    check("R8 negative rail", tap_out(1), -32768);
    check("R11 zero sample tap", tap_out(2), 0);

    // R1: reset mid-run clears weights
    do_reset();

    done = 1;
    finish_run();
  end

endmodule